// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This controller collects eight interrupt request lines and feeds a single processor interrupt with a vector index. Each line carries a fixed priority level that is set when the design is elaborated. A larger level means a more urgent source. The controller catches rising edges into pending flags and offers the most urgent eligible one to the processor. The processor takes the interrupt with an acknowledge strobe and closes its service routine with an end-of-service strobe.

A mode input chooses between two policies. In sequential mode, nothing is delivered while any routine is active. In nested mode, a source may break into a running routine only when its level is strictly above every routine already in service. Each source has an in-service flag. When a routine ends, the remaining pending requests are weighed again at once, with no extra cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is low, with nothing pending and nothing in service.
- R2: A request is recorded on the rising edge of its line and stays pending after the line drops. A line held high produces a single request.
- R3: Among eligible pending sources, `irq_vec` shows the one with the highest level. Ties go to the lower index. The default levels for sources 0 to 7 are 2, 4, 5, 1, 4, 0, 7, 3. `PRIO` holds source i in bits [3i+2:3i].
- R4: While `irq_out` is high and no acknowledge has come, `irq_out` stays high and `irq_vec` stays the same, even if a more urgent request arrives.
- R5: `ack` while `irq_out` is high clears the pending flag of the source on `irq_vec` and marks that source in service. `ack` while `irq_out` is low has no effect.
- R6: In sequential mode (`nest_mode`=0), `irq_out` stays low while any routine is in service, and new requests remain pending.
- R7: In sequential mode, `irq_out` rises in the cycle after the `eos` that ends the last routine, if a request is pending.
- R8: In nested mode (`nest_mode`=1), a pending source whose level is strictly above all in-service levels is delivered while those routines are still active.
- R9: In nested mode, a pending source whose level is equal to or below the highest in-service level is not delivered.
- R10: `eos` ends the in-service routine with the highest level. Pending requests are then weighed against the routines still active.
- R11: Each `eos` ends exactly one routine. A lower routine stays in service and keeps blocking sources at or below its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Request lines, one per source |
| nest_mode | input | 1 | 1 = nested priority, 0 = sequential |
| ack | input | 1 | Acknowledge strobe from the processor |
| eos | input | 1 | End-of-service strobe from the processor |
| irq_out | output | 1 | Interrupt to the processor |
| irq_vec | output | 3 | Index of the offered source |

## Verification
The checker assumes three things about the inputs:
- `nest_mode` changes only while no routine is in service and no interrupt is offered.
- `ack` and `eos` are never raised in the same cycle.
- `eos` arrives only for a routine that was actually acknowledged.

The bench keeps to these rules. It sets the mode only between scenarios, after every routine has been closed. It drives each strobe alone for one cycle. It balances every acknowledge with exactly one end-of-service.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int PW = 3,
  parameter logic [NSRC*PW-1:0] PRIO = {3'd3, 3'd7, 3'd0, 3'd4, 3'd1, 3'd5, 3'd4, 3'd2},
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            nest_mode,
  input  logic            ack,
  input  logic            eos,
  output logic            irq_out,
  output logic [IW-1:0]   irq_vec
);

  logic [NSRC-1:0] req_q, pend_q, insvc_q;
  logic [NSRC-1:0] rise, ack_mask, eos_mask;
  logic            hold_q;
  logic [IW-1:0]   hold_idx_q;

  logic            cand_v, act_v, eligible, take;
  logic [IW-1:0]   cand_idx, act_idx;
  logic [PW-1:0]   cand_pr, act_pr;

  always_comb begin
    cand_v = 1'b0; cand_idx = '0; cand_pr = '0;
    act_v  = 1'b0; act_idx  = '0; act_pr  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_q[i] && (!cand_v || PRIO[i*PW +: PW] > cand_pr)) begin
        cand_v = 1'b1; cand_idx = IW'(i); cand_pr = PRIO[i*PW +: PW];
      end
      if (insvc_q[i] && (!act_v || PRIO[i*PW +: PW] > act_pr)) begin
        act_v = 1'b1; act_idx = IW'(i); act_pr = PRIO[i*PW +: PW];
      end
    end
  end

  assign eligible = cand_v && (!act_v || (nest_mode && cand_pr > act_pr));
  assign irq_out  = hold_q | eligible;
  assign irq_vec  = hold_q ? hold_idx_q : cand_idx;
  assign take     = ack & irq_out;
  assign rise     = irq_req & ~req_q;
  assign ack_mask = take ? (NSRC'(1) << irq_vec) : '0;
  assign eos_mask = (eos && act_v) ? (NSRC'(1) << act_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q      <= '0;
      pend_q     <= '0;
      insvc_q    <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      req_q   <= irq_req;
      pend_q  <= (pend_q & ~ack_mask) | rise;
      insvc_q <= (insvc_q & ~eos_mask) | ack_mask;
      if (take) begin
        hold_q <= 1'b0;
      end else if (irq_out) begin
        hold_q     <= 1'b1;
        hold_idx_q <= irq_vec;
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NSRC = 8,
  parameter int PW = 3,
  parameter logic [NSRC*PW-1:0] PRIO = '0,
  localparam int IW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            nest_mode,
  input logic            ack,
  input logic            eos,
  input logic            irq_out,
  input logic [IW-1:0]   irq_vec,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] insvc_q
);

  logic outranks;
  always_comb begin
    outranks = 1'b1;
    for (int j = 0; j < NSRC; j++)
      if (insvc_q[j] && PRIO[int'(irq_vec)*PW +: PW] <= PRIO[j*PW +: PW])
        outranks = 1'b0;
  end

  p_offer_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> pend_q[irq_vec]);

  p_vec_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && !ack |=> irq_out && $stable(irq_vec));

  p_ack_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack && irq_out && !eos |=> insvc_q[$past(irq_vec)]);

  p_ack_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !irq_out && !eos |=> $stable(insvc_q));

  p_seq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !nest_mode && (insvc_q != '0) |-> !irq_out);

  p_nest_strict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nest_mode && irq_out |-> outranks);

  p_eos_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eos && !ack && (insvc_q != '0) |=> $countones(insvc_q) == $countones($past(insvc_q)) - 1);

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .PW(PW), .PRIO(PRIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .nest_mode(nest_mode), .ack(ack), .eos(eos),
  .irq_out(irq_out), .irq_vec(irq_vec), .pend_q(pend_q), .insvc_q(insvc_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic       nest_mode = 1'b1;
  logic       ack = 1'b0;
  logic       eos = 1'b0;
  logic       irq_out;
  logic [2:0] irq_vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nest_mode(nest_mode),
    .ack(ack), .eos(eos), .irq_out(irq_out), .irq_vec(irq_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_irq(input string tag, input bit on, input int vec);
    check({tag, " irq_out"}, int'(irq_out), int'(on));
    if (on) check({tag, " irq_vec"}, int'(irq_vec), vec);
  endtask

  task automatic raise(input logic [7:0] m);
    irq_req = irq_req | m;
    step();
    irq_req = irq_req & ~m;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_eos();
    eos = 1'b1; step(); eos = 1'b0;
  endtask

  task automatic t_reset();
    step();
    expect_irq("R1 reset", 1'b0, 0);
  endtask

  task automatic t_priority();
    nest_mode = 1'b1;
    raise(8'b0000_0111);
    expect_irq("R3 top of 2/4/5", 1'b1, 2);
    do_ack();
    expect_irq("R9 lower waits", 1'b0, 0);
    do_eos();
    expect_irq("R10 next after eos", 1'b1, 1);
    do_ack();
    expect_irq("R9 level 2 under 4", 1'b0, 0);
    do_eos();
    expect_irq("R10 last one", 1'b1, 0);
    do_ack(); do_eos();
    expect_irq("R5 all cleared", 1'b0, 0);
    raise(8'b0001_0010);
    expect_irq("R3 tie lower index", 1'b1, 1);
    do_ack();
    expect_irq("R9 equal level waits", 1'b0, 0);
    do_eos();
    expect_irq("R3 tie partner", 1'b1, 4);
    do_ack(); do_eos();
  endtask

  task automatic t_edge();
    nest_mode = 1'b1;
    irq_req[3] = 1'b1;
    step();
    expect_irq("R2 edge caught", 1'b1, 3);
    do_ack(); do_eos();
    step(); step();
    expect_irq("R2 level no repeat", 1'b0, 0);
    irq_req[3] = 1'b0;
    step();
    raise(8'b0000_1000);
    expect_irq("R2 new edge", 1'b1, 3);
    do_ack(); do_eos();
  endtask

  task automatic t_hold_preempt();
    nest_mode = 1'b1;
    raise(8'b0000_0001);
    expect_irq("R3 single", 1'b1, 0);
    raise(8'b0100_0000);
    expect_irq("R4 vector held", 1'b1, 0);
    step();
    expect_irq("R4 still held", 1'b1, 0);
    do_ack();
    expect_irq("R8 preempt", 1'b1, 6);
    do_ack();
    expect_irq("R5 both in service", 1'b0, 0);
    do_eos(); do_eos();
    expect_irq("R5 idle after two eos", 1'b0, 0);
  endtask

  task automatic t_nest_clear();
    nest_mode = 1'b1;
    raise(8'b0000_0001);
    do_ack();
    raise(8'b0000_0100);
    expect_irq("R8 level 5 over 2", 1'b1, 2);
    do_ack(); do_eos();
    raise(8'b0000_1000);
    expect_irq("R11 outer still blocks", 1'b0, 0);
    raise(8'b0000_0010);
    expect_irq("R10 inner ended", 1'b1, 1);
    do_ack(); do_eos();
    expect_irq("R11 outer still active", 1'b0, 0);
    do_eos();
    expect_irq("R10 held low one out", 1'b1, 3);
    do_ack(); do_eos();
    expect_irq("R11 clean", 1'b0, 0);
  endtask

  task automatic t_sequential();
    nest_mode = 1'b0;
    step();
    raise(8'b0000_0001);
    do_ack();
    raise(8'b0100_0000);
    expect_irq("R6 masked", 1'b0, 0);
    do_ack();
    expect_irq("R5 stray ack", 1'b0, 0);
    do_eos();
    expect_irq("R7 delivered after eos", 1'b1, 6);
    do_ack(); do_eos();
    expect_irq("R7 drained", 1'b0, 0);
    nest_mode = 1'b1;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    t_reset();
    t_priority();
    t_edge();
    t_hold_preempt();
    t_nest_clear();
    t_sequential();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule